// File: doc/BRIEF.md
# Paged ROM Byte Window

This block lets a processor reach a byte-wide ROM of up to 16 MiB through a pair of 8-bit I/O ports. It keeps a 24-bit pointer. The upper eight bits of the 16-bit I/O address are used as a second data byte. A write to the page port loads the two upper pointer bytes at once: one from the upper address byte and one from the data byte. A read of the fetch port loads the low pointer byte from the upper address byte and, in the same access, returns the ROM byte at the resulting pointer. A sequential scan therefore costs one I/O read per byte.

Accesses arrive on a valid/ready request channel. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The block holds `req_ready` low whenever a response is waiting that has not been taken. Fetch results leave on a valid/ready response channel. When `rsp_ready` is low, the response is held unchanged. The ROM array sits outside the block and is read synchronously: `rom_req` and `rom_addr` are presented in one cycle and `rom_rdata` is used in the next. A configurable ROM size bounds the window. Pointers at or beyond that size read as 0xFF and do not touch the array.

Top module: `romwin_top`

## Requirements
- R1: An accepted write (`req_wr`=1) whose `req_addr[7:0]` equals PORT_PAGE sets pointer bits 23:16 to `req_addr[15:8]` and bits 15:8 to `req_wdata`, and leaves bits 7:0 unchanged. No response is produced.
- R2: An accepted read (`req_wr`=0) whose `req_addr[7:0]` equals PORT_FETCH sets pointer bits 7:0 to `req_addr[15:8]` and leaves bits 23:8 unchanged. It returns the ROM byte at the updated pointer.
- R3: When the updated pointer of a fetch is not below the effective ROM size, the response data is 0xFF and `rom_req` stays low.
- R4: The effective ROM size is `cfg_rom_size` limited to 2^24. Any value of 2^24 or more makes the whole 24-bit space readable, and a value of zero makes every fetch return 0xFF.
- R5: A fetch accepted at clock edge N raises `rsp_valid` after edge N and keeps it until edge N+1. With `rsp_ready` held high, fetches on consecutive cycles are answered one per cycle, in order.
- R6: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` stays stable and `req_ready` is low, so no request is lost or reordered.
- R7: Reset clears the pointer to zero.
- R8: Only `req_addr[7:0]` is decoded. Writes to the fetch port, reads of the page port and accesses to any other port are accepted, leave the pointer unchanged and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rom_size | input | 25 | ROM size in bytes (values of 2^24 and above are limited to 2^24) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | I/O address: [7:0] port select, [15:8] data byte carried on the address |
| req_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | Fetch response valid |
| rsp_ready | input | 1 | Fetch response ready |
| rsp_data | output | 8 | Fetched ROM byte, or 0xFF when out of range |
| rom_req | output | 1 | Synchronous ROM read strobe |
| rom_addr | output | 24 | ROM byte address |
| rom_rdata | input | 8 | ROM data, valid the cycle after `rom_req` |

## Verification
The assertions assume that `cfg_rom_size` changes only while no fetch is in flight. They also assume the ROM model answers every `rom_req` in the next cycle. The bench changes the size only between access bursts, when no response is pending. Its ROM model registers a computed byte for each strobe. Requests are driven on the falling edge and held until accepted, so no access is dropped while `req_ready` is low.

// File: rtl/romwin_pkg.sv
package romwin_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_PAGE  = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/romwin_decode.sv
module romwin_decode
  import romwin_pkg::*;
#(
  parameter int          PORT_W     = 8,
  parameter logic [7:0]  PORT_PAGE  = 8'h40,
  parameter logic [7:0]  PORT_FETCH = 8'h41
) (
  input  logic              fire,
  input  logic              is_wr,
  input  logic [PORT_W-1:0] port,
  output acc_kind_e         kind
);
  always_comb begin
    kind = ACC_NONE;
    if (fire) begin
      if (is_wr && port == PORT_W'(PORT_PAGE))
        kind = ACC_PAGE;
      else if (!is_wr && port == PORT_W'(PORT_FETCH))
        kind = ACC_FETCH;
    end
  end
endmodule

// File: rtl/romwin_latch.sv
module romwin_latch
  import romwin_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 3 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_kind_e     kind,
  input  logic [DW-1:0] io_byte,
  input  logic [DW-1:0] wr_byte,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] fetch_ptr
);
  logic [AW-1:0] ptr_d;

  assign fetch_ptr = {ptr_q[AW-1:DW], io_byte};

  always_comb begin
    ptr_d = ptr_q;
    unique case (kind)
      ACC_PAGE:  ptr_d = {io_byte, wr_byte, ptr_q[DW-1:0]};
      ACC_FETCH: ptr_d = fetch_ptr;
      default:   ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/romwin_bound.sv
module romwin_bound #(
  parameter int AW = 24,
  localparam int SW = AW + 1
) (
  input  logic [AW-1:0] ptr,
  input  logic [SW-1:0] size,
  output logic          in_range
);
  localparam logic [SW-1:0] FULL = SW'(1) << AW;
  logic [SW-1:0] eff_size;

  assign eff_size = (size > FULL) ? FULL : size;
  assign in_range = {1'b0, ptr} < eff_size;
endmodule

// File: rtl/romwin_rsp.sv
module romwin_rsp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          issue_oob,
  input  logic [DW-1:0] rom_rdata,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          slot_free
);
  logic          infl_q, oob_q, hold_q;
  logic [DW-1:0] hold_data_q;
  logic [DW-1:0] live_data;

  assign live_data = oob_q ? {DW{1'b1}} : rom_rdata;
  assign rsp_valid = infl_q | hold_q;
  assign rsp_data  = hold_q ? hold_data_q : live_data;
  assign slot_free = !hold_q && (!infl_q || rsp_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      infl_q      <= 1'b0;
      oob_q       <= 1'b0;
      hold_q      <= 1'b0;
      hold_data_q <= '0;
    end else begin
      infl_q <= issue;
      oob_q  <= issue_oob;
      if (infl_q && !hold_q && !rsp_ready) begin
        hold_q      <= 1'b1;
        hold_data_q <= live_data;
      end else if (hold_q && rsp_ready) begin
        hold_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/romwin_top.sv
module romwin_top
  import romwin_pkg::*;
#(
  parameter int         DW         = 8,
  parameter logic [7:0] PORT_PAGE  = 8'h40,
  parameter logic [7:0] PORT_FETCH = 8'h41,
  localparam int AW  = 3 * DW,
  localparam int SW  = AW + 1,
  localparam int IOW = 2 * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SW-1:0]  cfg_rom_size,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_wr,
  input  logic [IOW-1:0] req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [DW-1:0]  rsp_data,
  output logic           rom_req,
  output logic [AW-1:0]  rom_addr,
  input  logic [DW-1:0]  rom_rdata
);
  acc_kind_e     kind;
  logic          fire, in_range, slot_free, fetch;
  logic [AW-1:0] ptr_q, fetch_ptr;

  assign req_ready = slot_free;
  assign fire      = req_valid && slot_free;
  assign fetch     = (kind == ACC_FETCH);

  romwin_decode #(.PORT_W(DW), .PORT_PAGE(PORT_PAGE), .PORT_FETCH(PORT_FETCH)) dec_i (
    .fire(fire), .is_wr(req_wr), .port(req_addr[DW-1:0]), .kind(kind)
  );

  romwin_latch #(.DW(DW)) lat_i (
    .clk(clk), .rst_n(rst_n), .kind(kind),
    .io_byte(req_addr[IOW-1:DW]), .wr_byte(req_wdata),
    .ptr_q(ptr_q), .fetch_ptr(fetch_ptr)
  );

  romwin_bound #(.AW(AW)) bnd_i (
    .ptr(fetch_ptr), .size(cfg_rom_size), .in_range(in_range)
  );

  assign rom_req  = fetch && in_range;
  assign rom_addr = fetch_ptr;

  romwin_rsp #(.DW(DW)) rsp_i (
    .clk(clk), .rst_n(rst_n), .issue(fetch), .issue_oob(fetch && !in_range),
    .rom_rdata(rom_rdata), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .slot_free(slot_free)
  );
endmodule

// File: rtl/romwin_chk.sv
module romwin_chk #(
  parameter int         DW         = 8,
  parameter logic [7:0] PORT_PAGE  = 8'h40,
  parameter logic [7:0] PORT_FETCH = 8'h41,
  localparam int AW  = 3 * DW,
  localparam int SW  = AW + 1,
  localparam int IOW = 2 * DW
) (
  input logic           clk,
  input logic           rst_n,
  input logic [SW-1:0]  cfg_rom_size,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_wr,
  input logic [IOW-1:0] req_addr,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [DW-1:0]  rsp_data,
  input logic           rom_req,
  input logic [AW-1:0]  rom_addr
);
  logic acc_fetch, acc_other;
  assign acc_fetch = req_valid && req_ready && !req_wr && req_addr[DW-1:0] == DW'(PORT_FETCH);
  assign acc_other = req_valid && req_ready && !(!req_wr && req_addr[DW-1:0] == DW'(PORT_FETCH));

  AST_FETCH_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fetch |-> rom_addr[DW-1:0] == req_addr[IOW-1:DW]);                 // R2
  AST_ROM_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |-> ({1'b0, rom_addr} < cfg_rom_size));                          // R3
  AST_ZERO_SIZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rom_size == '0) |-> !rom_req);                                      // R4
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fetch |=> rsp_valid);                                                // R5
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));        // R6
  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);                               // R6
  AST_OTHER_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_other && !rsp_valid) |=> !rsp_valid);                               // R8
  AST_STROBE_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |-> acc_fetch);                                                  // R8
endmodule

bind romwin_top romwin_chk #(.DW(DW), .PORT_PAGE(PORT_PAGE), .PORT_FETCH(PORT_FETCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_rom_size(cfg_rom_size),
  .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rom_req(rom_req), .rom_addr(rom_addr)
);

// File: tb/romwin_top_tb_top.sv
module romwin_top_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam logic [7:0] P_PAGE  = 8'h40;
  localparam logic [7:0] P_FETCH = 8'h41;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [24:0] cfg_rom_size = '0;
  logic        req_valid = 1'b0, req_wr = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, rom_req;
  logic [7:0]  rsp_data, rom_rdata;
  logic [23:0] rom_addr;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [23:0] m_ptr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  romwin_top #(.PORT_PAGE(P_PAGE), .PORT_FETCH(P_FETCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_rom_size(cfg_rom_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_rdata(rom_rdata)
  );

  function automatic logic [7:0] rom_fn(logic [23:0] a);
    return (a[7:0] + 8'(3 * a[15:8]) + 8'(7 * a[23:16])) ^ 8'hA5;
  endfunction

  always @(posedge clk) if (rom_req) rom_rdata <= rom_fn(rom_addr);

  function automatic logic [7:0] expect_byte(logic [23:0] a, logic [24:0] sz);
    logic [24:0] cap = (sz > 25'h1000000) ? 25'h1000000 : sz;
    return ({1'b0, a} < cap) ? rom_fn(a) : 8'hFF;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_port(logic [7:0] port, logic [7:0] hi, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_wr = 1; req_addr = {hi, port}; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check("R8 no response to write", 32'(rsp_valid), 0);
    if (port == P_PAGE) m_ptr = {hi, d, m_ptr[7:0]};
  endtask

  task automatic fetch(string req, logic [7:0] pg);
    @(negedge clk);
    req_valid = 1; req_wr = 0; req_addr = {pg, P_FETCH};
    @(negedge clk);
    req_valid = 0;
    m_ptr[7:0] = pg;
    check(req, 32'(rsp_valid), 1);
    check(req, 32'(rsp_data), 32'(expect_byte(m_ptr, cfg_rom_size)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cfg_rom_size = 25'h140;
    repeat (3) @(negedge clk);
    check("R7 reset rsp_valid", 32'(rsp_valid), 0);
    check("R7 reset req_ready", 32'(req_ready), 1);
    rst_n = 1;
    // R7: pointer zero after reset, fetch page 0 reads address 0
    fetch("R7 reset pointer", 8'h00);
    check("R7 addr0 byte", 32'(rsp_data), 32'(rom_fn(24'h0)));

    // R2: full sweep of low byte in page 0
    for (int i = 0; i < 256; i++) fetch("R2 sweep page0", 8'(i));
    // R1 + R3: page 1, boundary at 0x140
    wr_port(P_PAGE, 8'h00, 8'h01);
    for (int i = 0; i < 256; i++) fetch("R3 sweep page1 bound", 8'(i));
    // R1: low byte kept across page write
    fetch("R1 setup", 8'h3C);
    cfg_rom_size = 25'h1000000;
    @(negedge clk);
    wr_port(P_PAGE, 8'h12, 8'h34);
    check("R1 pointer low kept", 32'(m_ptr), 32'h12343C);
    fetch("R1 composed pointer", 8'h3C);

    // R8: other accesses leave pointer unchanged, no response
    wr_port(8'h42, 8'hEE, 8'hDD);
    wr_port(P_FETCH, 8'hEE, 8'hDD);
    @(negedge clk);
    req_valid = 1; req_wr = 0; req_addr = {8'h77, P_PAGE};
    @(negedge clk);
    req_valid = 0;
    check("R8 read of page port silent", 32'(rsp_valid), 0);
    fetch("R8 pointer unchanged", 8'h3C);
    check("R8 pointer bytes", 32'(rom_fn(24'h12343C)), 32'(rsp_data));

    // R4: top of space with cap and just below size
    wr_port(P_PAGE, 8'hFF, 8'hFF);
    cfg_rom_size = 25'h1FFFFFF;
    @(negedge clk);
    fetch("R4 cap allows top", 8'hFF);
    cfg_rom_size = 25'h0FFFFFF;
    @(negedge clk);
    fetch("R4 size excludes top", 8'hFF);
    check("R4 top is FF", 32'(rsp_data), 32'hFF);
    fetch("R4 below size", 8'hFE);
    cfg_rom_size = 25'h0;
    @(negedge clk);
    wr_port(P_PAGE, 8'h00, 8'h00);
    for (int i = 0; i < 16; i++) fetch("R4 zero size FF", 8'(i * 16));

    // R5: back-to-back fetches in order
    cfg_rom_size = 25'h1000000;
    wr_port(P_PAGE, 8'h05, 8'h80);
    @(negedge clk);
    for (int i = 0; i < 17; i++) begin
      if (i > 0) begin
        check("R5 b2b valid", 32'(rsp_valid), 1);
        check("R5 b2b order", 32'(rsp_data), 32'(rom_fn({16'h0580, 8'(i * 9 - 9)})));
      end
      check("R5 b2b ready", 32'(req_ready), 1);
      if (i < 16) begin
        req_valid = 1; req_wr = 0; req_addr = {8'(i * 9), P_FETCH};
      end else req_valid = 0;
      @(negedge clk);
    end
    m_ptr[7:0] = 8'(15 * 9);

    // R6: back-pressure
    rsp_ready = 0;
    req_valid = 1; req_wr = 0; req_addr = {8'h21, P_FETCH};
    @(negedge clk);
    check("R6 stall valid", 32'(rsp_valid), 1);
    check("R6 stall data", 32'(rsp_data), 32'(rom_fn(24'h058021)));
    check("R6 stall not ready", 32'(req_ready), 0);
    req_addr = {8'h22, P_FETCH};
    @(negedge clk);
    check("R6 held data", 32'(rsp_data), 32'(rom_fn(24'h058021)));
    check("R6 held not ready", 32'(req_ready), 0);
    rsp_ready = 1;
    @(negedge clk);
    check("R6 drained", 32'(rsp_valid), 0);
    check("R6 ready again", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    check("R6 second in order", 32'(rsp_data), 32'(rom_fn(24'h058022)));
    check("R6 second valid", 32'(rsp_valid), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule